// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps, for one hardware thread, an ordered log of every destination-register rename made by the rename stage. Each record carries the instruction's sequence number, the architectural register that was renamed, the physical register newly allocated to it, and the physical register that held the mapping before. Records are appended at the young end as renames happen.

Three walks drain the log, each retiring one record per clock. A commit walk starts from the old end and hands each record's previous physical register back to the free list, because no younger instruction can read it any more. A squash walk starts from the young end. For each record it undoes the rename by writing the previous physical register back into the map table and returning the new physical register to the free list. A flush does the same as a squash, but for every record, and leaves the log empty. Physical indices at or above the count of real integer and float registers name special registers. When one of those is released by a squash or flush, a scoreboard-ready write for it goes out as well. The map table, free list and scoreboard sit outside this block and receive its registered write strobes. `DEPTH` must be a power of two.

Top module: `rename_hist_buf`

## Requirements
- R1: A push is accepted only when the block is idle (`busy` low), not `full`, and no commit, squash or flush is presented in the same cycle. An accepted record becomes the youngest. `full` is high exactly when `DEPTH` records are held, `empty` exactly when none are, and a push refused for any of these reasons leaves the buffer unchanged.
- R2: A squash with sequence number S removes every record whose sequence number is greater than S, youngest first, one per cycle. Each removal emits a map write of (architectural register, previous physical register).
- R3: In the same output cycle as each squash or flush map write, the record's new physical register is emitted on the free-list write.
- R4: When a squashed or flushed record's new physical register index is greater than or equal to `NUM_PHYS`, a scoreboard-ready write for that index is emitted in the same cycle. Below `NUM_PHYS` no ready write occurs.
- R5: A commit with sequence number C removes records whose sequence number is less than or equal to C, oldest first, one per cycle. Each removal emits a free-list write of the previous physical register and no map write.
- R6: A commit is ignored when the buffer is empty or the oldest sequence number exceeds C: no write is emitted and every record stays.
- R7: A squash on an empty buffer, or one with no record younger than S, emits no write.
- R8: A commit is not accepted in a cycle that presents a squash or flush, nor while a squash or flush walk is busy. A squash or flush presented during a commit walk takes over at once, and the commit walk stops.
- R9: A flush undoes every record as a squash would and leaves `empty` high.
- R10: All write strobes are registered: they appear one cycle after the step that produced them, at most one record per cycle. `busy` rises the cycle after a walk is accepted and falls after the walk finds nothing left. Reset clears the buffer and all strobes.
- R11: Sequence numbers are compared as unsigned `SEQ_W`-bit values (for example 0x8000 is greater than 0x7FFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Append a record |
| push_seq | input | SEQ_W | Sequence number of the record |
| push_areg | input | AREG_W | Architectural register renamed |
| push_pnew | input | PREG_W | Newly allocated physical register |
| push_pold | input | PREG_W | Previous physical mapping |
| commit_valid | input | 1 | Start a commit walk |
| commit_seq | input | SEQ_W | Last committed sequence number |
| squash_valid | input | 1 | Start a squash walk |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| flush | input | 1 | Undo all records |
| map_we | output | 1 | Map-table restore strobe |
| map_areg | output | AREG_W | Architectural register to restore |
| map_preg | output | PREG_W | Physical register to restore it to |
| free_we | output | 1 | Free-list release strobe |
| free_preg | output | PREG_W | Physical register released |
| rdy_we | output | 1 | Scoreboard-ready strobe |
| rdy_preg | output | PREG_W | Special register marked ready |
| busy | output | 1 | A walk is in progress |
| full | output | 1 | DEPTH records held |
| empty | output | 1 | No records held |

## Verification
The bench keeps its own queue of records and, on every clock, predicts each strobe and flag, so any deviation in walk direction shows up at once. A squash that walked from the old end would restore the wrong architectural register first. A commit that emitted the new register instead of the previous one would put the live register on the free list. Other cases pushed hard: a commit whose oldest sequence number is above C, which a faulty design would partly drain; a commit arriving alongside a squash, which, if accepted, would free one record too many; a squash landing mid-commit; sequence numbers straddling the top bit, which a signed compare would order backwards; and pushes into a full buffer, which would overwrite the oldest record.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2,
    WALK_FLUSH  = 2'd3
  } walk_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int REC_W = SEQ_W + AREG_W + 2 * PREG_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [REC_W-1:0]  wr_rec,
  input  logic [PTR_W-1:0]  yng_addr,
  output logic [REC_W-1:0]  yng_rec,
  input  logic [PTR_W-1:0]  old_addr,
  output logic [REC_W-1:0]  old_rec
);
  // Distributed-RAM style: one write port, two asynchronous read ports.
  logic [REC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_rec;
  end

  assign yng_rec = mem[yng_addr];
  assign old_rec = mem[old_addr];
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int AREG_W   = 5,
  parameter int PREG_W   = 7,
  parameter int NUM_PHYS = 96,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int REC_W = SEQ_W + AREG_W + 2 * PREG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              flush,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [PTR_W-1:0]  yng_addr,
  input  logic [REC_W-1:0]  yng_rec,
  output logic [PTR_W-1:0]  old_addr,
  input  logic [REC_W-1:0]  old_rec,
  output logic              map_we,
  output logic [AREG_W-1:0] map_areg,
  output logic [PREG_W-1:0] map_preg,
  output logic              free_we,
  output logic [PREG_W-1:0] free_preg,
  output logic              rdy_we,
  output logic [PREG_W-1:0] rdy_preg,
  output logic              busy,
  output logic              full,
  output logic              empty
);
  localparam logic [PREG_W:0] SPECIAL_BASE = (PREG_W + 1)'(NUM_PHYS);

  walk_e            state_q;
  logic [SEQ_W-1:0] limit_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  // Record fields: {seq, areg, pnew, pold}
  logic [SEQ_W-1:0]  y_seq, o_seq;
  logic [AREG_W-1:0] y_areg, o_areg;
  logic [PREG_W-1:0] y_pnew, y_pold, o_pnew, o_pold;
  assign {y_seq, y_areg, y_pnew, y_pold} = yng_rec;
  assign {o_seq, o_areg, o_pnew, o_pold} = old_rec;

  logic undo_walk, acc_flush, acc_squash, acc_commit, acc_push;
  logic sq_step, fl_step, cm_step, pop_young, pop_old, take_over;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign busy      = (state_q != WALK_IDLE);
  assign undo_walk = (state_q == WALK_SQUASH) || (state_q == WALK_FLUSH);

  assign acc_flush  = flush && !undo_walk;
  assign acc_squash = squash_valid && !flush && !undo_walk;
  assign take_over  = acc_flush || acc_squash;
  assign acc_commit = commit_valid && !squash_valid && !flush && !busy;
  assign acc_push   = push_valid && !busy && !full && !commit_valid
                      && !squash_valid && !flush;

  assign sq_step = !take_over && state_q == WALK_SQUASH && !empty && (y_seq > limit_q);
  assign fl_step = !take_over && state_q == WALK_FLUSH && !empty;
  assign cm_step = !take_over && state_q == WALK_COMMIT && !empty && (o_seq <= limit_q);
  assign pop_young = sq_step || fl_step;
  assign pop_old   = cm_step;

  assign wr_en    = acc_push;
  assign wr_addr  = tail_q;
  assign yng_addr = tail_q - 1'b1;
  assign old_addr = head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WALK_IDLE;
      limit_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (acc_flush) begin
        state_q <= WALK_FLUSH;
      end else if (acc_squash) begin
        state_q <= WALK_SQUASH;
        limit_q <= squash_seq;
      end else if (acc_commit) begin
        state_q <= WALK_COMMIT;
        limit_q <= commit_seq;
      end else if (busy && !pop_young && !pop_old) begin
        state_q <= WALK_IDLE;
      end
      if (acc_push) begin
        tail_q <= tail_q + 1'b1;
        cnt_q  <= cnt_q + 1'b1;
      end else if (pop_young) begin
        tail_q <= tail_q - 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end else if (pop_old) begin
        head_q <= head_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_we    <= 1'b0;
      map_areg  <= '0;
      map_preg  <= '0;
      free_we   <= 1'b0;
      free_preg <= '0;
      rdy_we    <= 1'b0;
      rdy_preg  <= '0;
    end else begin
      map_we  <= pop_young;
      free_we <= pop_young || pop_old;
      rdy_we  <= pop_young && ({1'b0, y_pnew} >= SPECIAL_BASE);
      if (pop_young) begin
        map_areg  <= y_areg;
        map_preg  <= y_pold;
        free_preg <= y_pnew;
        rdy_preg  <= y_pnew;
      end else if (pop_old) begin
        free_preg <= o_pold;
      end
    end
  end
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf #(
  parameter int DEPTH    = 8,
  parameter int SEQ_W    = 16,
  parameter int AREG_W   = 5,
  parameter int PREG_W   = 7,
  parameter int NUM_PHYS = 96,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int REC_W = SEQ_W + AREG_W + 2 * PREG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_pnew,
  input  logic [PREG_W-1:0] push_pold,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              flush,
  output logic              map_we,
  output logic [AREG_W-1:0] map_areg,
  output logic [PREG_W-1:0] map_preg,
  output logic              free_we,
  output logic [PREG_W-1:0] free_preg,
  output logic              rdy_we,
  output logic [PREG_W-1:0] rdy_preg,
  output logic              busy,
  output logic              full,
  output logic              empty
);
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, yng_addr, old_addr;
  logic [REC_W-1:0] yng_rec, old_rec;

  rhb_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)
  ) store_i (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_rec   ({push_seq, push_areg, push_pnew, push_pold}),
    .yng_addr (yng_addr),
    .yng_rec  (yng_rec),
    .old_addr (old_addr),
    .old_rec  (old_rec)
  );

  rhb_ctrl #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
    .NUM_PHYS(NUM_PHYS)
  ) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .push_valid   (push_valid),
    .commit_valid (commit_valid),
    .commit_seq   (commit_seq),
    .squash_valid (squash_valid),
    .squash_seq   (squash_seq),
    .flush        (flush),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .yng_addr     (yng_addr),
    .yng_rec      (yng_rec),
    .old_addr     (old_addr),
    .old_rec      (old_rec),
    .map_we       (map_we),
    .map_areg     (map_areg),
    .map_preg     (map_preg),
    .free_we      (free_we),
    .free_preg    (free_preg),
    .rdy_we       (rdy_we),
    .rdy_preg     (rdy_preg),
    .busy         (busy),
    .full         (full),
    .empty        (empty)
  );
endmodule

// File: rtl/rename_hist_buf_chk.sv
module rename_hist_buf_chk #(
  parameter int PREG_W   = 7,
  parameter int NUM_PHYS = 96
) (
  input logic              clk,
  input logic              rst,
  input logic              map_we,
  input logic              free_we,
  input logic              rdy_we,
  input logic [PREG_W-1:0] rdy_preg,
  input logic              busy,
  input logic              full,
  input logic              empty
);
  // R3
  map_free_pair_chk: assert property (@(posedge clk) disable iff (rst)
    map_we |-> free_we);

  // R4
  rdy_special_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_we |-> (map_we && ({1'b0, rdy_preg} >= (PREG_W + 1)'(NUM_PHYS))));

  // R10
  strobe_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    free_we |-> $past(busy));

  // R1
  full_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !empty);

  // R10
  walk_ends_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !free_we);
endmodule

bind rename_hist_buf rename_hist_buf_chk #(
  .PREG_W(PREG_W), .NUM_PHYS(NUM_PHYS)
) chk_i (
  .clk(clk), .rst(rst), .map_we(map_we), .free_we(free_we),
  .rdy_we(rdy_we), .rdy_preg(rdy_preg), .busy(busy),
  .full(full), .empty(empty)
);

// File: tb/rename_hist_buf_tb_top.sv
module rename_hist_buf_tb_top;
  localparam int DEPTH = 8, SEQ_W = 16, AREG_W = 5, PREG_W = 7, NUM_PHYS = 96;

  logic clk = 1'b0, rst = 1'b1;
  logic push_valid = 0, commit_valid = 0, squash_valid = 0, flush = 0;
  logic [SEQ_W-1:0]  push_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [AREG_W-1:0] push_areg = 0;
  logic [PREG_W-1:0] push_pnew = 0, push_pold = 0;
  logic map_we, free_we, rdy_we, busy, full, empty;
  logic [AREG_W-1:0] map_areg;
  logic [PREG_W-1:0] map_preg, free_preg, rdy_preg;

  always #2.5 clk = ~clk;

  rename_hist_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
    .PREG_W(PREG_W), .NUM_PHYS(NUM_PHYS)) dut_i (.*);

  int checks = 0, errors = 0;
  int map_cnt = 0, free_cnt = 0, rdy_cnt = 0;
  logic [AREG_W-1:0] last_areg;
  logic [PREG_W-1:0] last_free;

  typedef struct {
    logic [SEQ_W-1:0] seq; logic [AREG_W-1:0] areg;
    logic [PREG_W-1:0] pnew; logic [PREG_W-1:0] pold;
  } rec_t;
  rec_t q[$];
  rec_t r;
  int mode = 0; // 0 idle, 1 squash, 2 commit, 3 flush
  logic [SEQ_W-1:0] lim;
  logic e_map, e_free, e_rdy;
  logic [AREG_W-1:0] e_areg;
  logic [PREG_W-1:0] e_mpreg, e_fpreg, e_rpreg;
  bit undo, t_fl, t_sq, t_cm, t_push, stepped;

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk) begin
    e_map = 0; e_free = 0; e_rdy = 0;
    if (rst) begin
      q.delete(); mode = 0;
    end else begin
      undo   = (mode == 1 || mode == 3);
      t_fl   = flush && !undo;
      t_sq   = squash_valid && !flush && !undo;
      t_cm   = commit_valid && !squash_valid && !flush && mode == 0;
      t_push = push_valid && mode == 0 && q.size() < DEPTH
               && !commit_valid && !squash_valid && !flush;
      stepped = 0;
      if (!t_fl && !t_sq && mode != 0) begin
        if ((mode == 1 || mode == 3) && q.size() > 0 &&
            (mode == 3 || q[q.size()-1].seq > lim)) begin
          r = q.pop_back();
          e_map = 1; e_areg = r.areg; e_mpreg = r.pold;
          e_free = 1; e_fpreg = r.pnew;
          if (int'(r.pnew) >= NUM_PHYS) begin e_rdy = 1; e_rpreg = r.pnew; end
          stepped = 1;
        end else if (mode == 2 && q.size() > 0 && q[0].seq <= lim) begin
          r = q.pop_front();
          e_free = 1; e_fpreg = r.pold;
          stepped = 1;
        end
        if (!stepped) mode = 0;
      end
      if (t_fl) mode = 3;
      else if (t_sq) begin mode = 1; lim = squash_seq; end
      else if (t_cm) begin mode = 2; lim = commit_seq; end
      if (t_push) q.push_back('{push_seq, push_areg, push_pnew, push_pold});
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (map_we) begin map_cnt++; last_areg = map_areg; end
      if (free_we) begin free_cnt++; last_free = free_preg; end
      if (rdy_we) rdy_cnt++;
      chk(map_we === e_map, "R2", "map_we", map_we, e_map);
      if (e_map) chk(map_areg === e_areg && map_preg === e_mpreg, "R2", "map data",
                     {map_areg, map_preg}, {e_areg, e_mpreg});
      chk(free_we === e_free, "R3 R5", "free_we", free_we, e_free);
      if (e_free) chk(free_preg === e_fpreg, "R3 R5", "free_preg", free_preg, e_fpreg);
      chk(rdy_we === e_rdy, "R4", "rdy_we", rdy_we, e_rdy);
      if (e_rdy) chk(rdy_preg === e_rpreg, "R4", "rdy_preg", rdy_preg, e_rpreg);
      chk(busy === (mode != 0), "R10", "busy", busy, mode != 0);
      chk(full === (q.size() == DEPTH), "R1", "full", full, q.size() == DEPTH);
      chk(empty === (q.size() == 0), "R1", "empty", empty, q.size() == 0);
    end
  end

  task automatic clear_cnt(); map_cnt = 0; free_cnt = 0; rdy_cnt = 0; endtask
  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask
  task automatic do_push(input int s, input int a, input int pn, input int po);
    push_valid = 1; push_seq = SEQ_W'(s); push_areg = AREG_W'(a);
    push_pnew = PREG_W'(pn); push_pold = PREG_W'(po);
    @(negedge clk); push_valid = 0;
  endtask
  task automatic do_squash(input int s);
    squash_valid = 1; squash_seq = SEQ_W'(s); @(negedge clk); squash_valid = 0; settle();
  endtask
  task automatic do_commit(input int c);
    commit_valid = 1; commit_seq = SEQ_W'(c); @(negedge clk); commit_valid = 0; settle();
  endtask
  task automatic do_flush();
    flush = 1; @(negedge clk); flush = 0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && empty && !full && !map_we && !free_we && !rdy_we, "R10", "reset state",
        {busy, empty, full}, 3'b010);
    rst = 0;
    @(negedge clk);

    // R2 squash youngest first
    for (int i = 1; i <= 4; i++) do_push(i, i, 40 + i, 10 + i);
    clear_cnt(); do_squash(2);
    chk(map_cnt == 2, "R2", "squash removals", map_cnt, 2);
    chk(last_areg == 3, "R2", "last restored areg", last_areg, 3);

    // R5 commit oldest first
    clear_cnt(); do_commit(1);
    chk(free_cnt == 1 && map_cnt == 0, "R5", "commit frees", free_cnt, 1);
    chk(last_free == 11, "R5", "commit freed pold", last_free, 11);

    // R6 commit with oldest above C is ignored; record stays
    clear_cnt(); do_commit(1);
    chk(free_cnt == 0, "R6", "ignored commit", free_cnt, 0);
    clear_cnt(); do_flush();
    chk(free_cnt == 1 && empty, "R6", "record kept then flushed", free_cnt, 1);

    // R7 squash on empty
    clear_cnt(); do_squash(0);
    chk(map_cnt == 0 && free_cnt == 0, "R7", "empty squash", free_cnt, 0);

    // R1 fill, refuse overflow push, R9 flush all, R4 special regs
    for (int i = 0; i < DEPTH + 2; i++) do_push(20 + i, i, 90 + i, i);
    chk(full == 1, "R1", "full after fill", full, 1);
    clear_cnt(); do_flush();
    chk(free_cnt == DEPTH, "R9", "flush count", free_cnt, DEPTH);
    chk(rdy_cnt == 2, "R4", "special ready writes", rdy_cnt, 2);
    chk(empty == 1, "R9", "empty after flush", empty, 1);

    // R8 commit dropped alongside a squash
    for (int i = 1; i <= 3; i++) do_push(i, i, 40 + i, 10 + i);
    clear_cnt();
    commit_valid = 1; commit_seq = 3; squash_valid = 1; squash_seq = 1;
    @(negedge clk); commit_valid = 0; squash_valid = 0; settle();
    chk(free_cnt == 2 && map_cnt == 2, "R8", "squash only", free_cnt, 2);
    clear_cnt(); do_flush();
    chk(free_cnt == 1, "R8", "commit dropped", free_cnt, 1);

    // R8 squash taking over a commit walk
    for (int i = 1; i <= 4; i++) do_push(i, i, 40 + i, 10 + i);
    clear_cnt();
    commit_valid = 1; commit_seq = 4; @(negedge clk); commit_valid = 0;
    @(negedge clk);
    squash_valid = 1; squash_seq = 0; @(negedge clk); squash_valid = 0; settle();
    chk(empty == 1 && free_cnt == 4, "R8", "takeover drains", free_cnt, 4);

    // R11 unsigned compare across the top bit
    do_push(16'h8000, 7, 50, 5);
    clear_cnt(); do_commit(16'h7FFF);
    chk(free_cnt == 0, "R11", "0x8000 above 0x7FFF", free_cnt, 0);
    clear_cnt(); do_squash(16'h7FFF);
    chk(map_cnt == 1 && empty, "R11", "unsigned squash", map_cnt, 1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule